// File: doc/BRIEF.md
# Masked Configuration Register Space

This block is the configuration register file of one bus function. It owns a 256-byte register space. An incoming 32-bit configuration address carries a bus number, a device/function number and a register offset. When the bus and device/function match the block's own identity, the access is served. Otherwise the access is dropped, and a read returns all ones.

Every written byte passes through a write mask that is fixed at elaboration. The mask comes from simple rules for the header fields and from the size of each base register's window. Read-only identity fields, type bits and the low-order sizing bits of base registers therefore cannot be overwritten. Software sizes a window by writing all ones and reading back the result.

Accesses are 1, 2 or 4 bytes wide and little-endian, and may start at any offset. Writes take effect on the next clock edge. Read data is registered and arrives one cycle after the request.

Top module: `cfg_space`

## Requirements
- R1: `sz` selects the access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. The byte at offset+k is on data bits [8k+7:8k]. Read lanes beyond the access width return zero.
- R2: Each written byte becomes (old & ~mask) | (new & mask), where the mask is fixed per offset.
- R3: In the command byte at offset 0x04, only bits 2:0 (I/O enable, memory enable, bus master) are writable. Offsets 0x05 to 0x07 read zero and ignore writes.
- R4: Offset 0x0C (cache line size), offset 0x3C (interrupt line) and every offset from 0x40 to 0xFF are fully writable.
- R5: Base register b sits at offset 0x10+4b (b = 0..5). For a window of size S, its writable mask is ~(S-1). A base register with S = 0 reads zero and ignores writes. Bit 0 of an I/O base register reads 1.
- R6: The expansion ROM base register at 0x30 has mask ~(S-1) | 1, so its enable bit 0 is writable. With size 0 it reads zero.
- R7: The identity fields come from parameters and are read-only: vendor at 0x00–0x01, device at 0x02–0x03, revision at 0x08, class at 0x09–0x0B, header type at 0x0E, interrupt pin at 0x3D.
- R8: Address decode is bus = addr[23:16], device/function = addr[15:8], offset = addr[7:0]. A write to a non-matching target changes nothing. A read from a non-matching target returns all ones of the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R9: Bytes past offset 0xFF are neither written nor returned. The offset does not wrap to 0x00, and those read lanes return zero.
- R10: Reset restores every byte to its default. The command, cache line size, interrupt line and device-specific area become zero. The low byte of each I/O base register becomes 0x01, and every other base register and the ROM base register become zero.
- R11: A write is visible to a read issued in the next cycle. `rvalid` rises exactly one cycle after a read request and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Configuration address (bus, device/function, offset) |
| sz | input | 2 | Access width code |
| wdata | input | 32 | Write data, little-endian |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Registered read data |

## Verification
The checker asserts on every cycle that `rvalid` follows a read request by exactly one cycle and appears at no other time. It also asserts that reads of a foreign target return ones in the low lane and zeros above the access width, and that the upper command bits never become set. Only the bench's scenarios can show the effect of the per-offset masks. These include the sizing readback of base and ROM registers, the immunity of the identity fields, the clipping of accesses at offset 0xFF, the isolation of foreign-target writes and the restoration of defaults on a second reset.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter logic [7:0]   BUS_NUM    = 8'h00,
  parameter logic [7:0]   DEVFN      = 8'h18,
  parameter logic [15:0]  VENDOR     = 16'h1AB7,
  parameter logic [15:0]  DEVICE     = 16'h0C31,
  parameter logic [23:0]  CLASS_CODE = 24'h020000,
  parameter logic [7:0]   REVISION   = 8'h02,
  parameter logic [7:0]   HDR_TYPE   = 8'h00,
  parameter logic [7:0]   INT_PIN    = 8'h01,
  parameter int           NUM_BARS   = 6,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES = {128'd0, 32'd32, 32'd4096},
  parameter logic [NUM_BARS-1:0]    BAR_IO    = 6'b000010,
  parameter logic [31:0]  ROM_SIZE   = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [1:0]  sz,
  input  logic [31:0] wdata,
  output logic        rvalid,
  output logic [31:0] rdata
);
  localparam int SPACE   = 256;
  localparam int BAR_LO  = 16;
  localparam int BAR_HI  = BAR_LO + 4*NUM_BARS;
  localparam int ROM_OFS = 48;

  logic [7:0] cfg_q [SPACE];

  function automatic logic [7:0] wmask_f(int i);
    logic [31:0] m;
    m = 32'd0;
    if (i >= BAR_LO && i < BAR_HI) begin
      m = BAR_SIZES[32*((i-BAR_LO)/4) +: 32];
      m = (m == 32'd0) ? 32'd0 : ~(m - 32'd1);
      return m[8*((i-BAR_LO)%4) +: 8];
    end
    if (i >= ROM_OFS && i < ROM_OFS + 4) begin
      m = (ROM_SIZE == 32'd0) ? 32'd0 : (~(ROM_SIZE - 32'd1) | 32'd1);
      return m[8*(i-ROM_OFS) +: 8];
    end
    if (i == 4)                   return 8'h07;
    if (i == 12 || i == 60)       return 8'hFF;
    if (i >= 64)                  return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] init_f(int i);
    if (i >= BAR_LO && i < BAR_HI && (i-BAR_LO)%4 == 0)
      return {7'd0, BAR_IO[(i-BAR_LO)/4] && BAR_SIZES[32*((i-BAR_LO)/4) +: 32] != 32'd0};
    case (i)
      0:  return VENDOR[7:0];
      1:  return VENDOR[15:8];
      2:  return DEVICE[7:0];
      3:  return DEVICE[15:8];
      8:  return REVISION;
      9:  return CLASS_CODE[7:0];
      10: return CLASS_CODE[15:8];
      11: return CLASS_CODE[23:16];
      14: return HDR_TYPE;
      61: return INT_PIN;
      default: return 8'h00;
    endcase
  endfunction

  wire        hit   = (addr[23:16] == BUS_NUM) && (addr[15:8] == DEVFN);
  wire [7:0]  ofs   = addr[7:0];
  wire        wr_go = req && we && hit;
  wire        rd_go = req && !we;
  wire        unused_hi = ^addr[31:24];
  wire [2:0]  nbytes = (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPACE; i++) cfg_q[i] <= init_f(i);
    end else if (wr_go) begin
      for (int i = 0; i < SPACE; i++)
        if (i >= int'(ofs) && i - int'(ofs) < int'(nbytes))
          cfg_q[i] <= (cfg_q[i] & ~wmask_f(i)) |
                      (wdata[8*(i-int'(ofs)) +: 8] & wmask_f(i));
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = 32'd0;
    if (!hit)
      rd_word = (nbytes == 3'd1) ? 32'h0000_00FF :
                (nbytes == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    else
      for (int k = 0; k < 4; k++)
        if (k < int'(nbytes) && int'(ofs) + k < SPACE)
          rd_word[8*k +: 8] = cfg_q[int'(ofs) + k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= 32'd0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) rdata <= rd_word;
    end
  end
endmodule

module cfg_space_chk #(
  parameter logic [7:0] BUS_NUM = 8'h00,
  parameter logic [7:0] DEVFN   = 8'h18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [31:0] addr,
  input logic [1:0]  sz,
  input logic        rvalid,
  input logic [31:0] rdata,
  input logic [7:0]  cmd_byte
);
  wire foreign = (addr[23:16] != BUS_NUM) || (addr[15:8] != DEVFN);

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);
  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);
  assert_foreign_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && foreign) |=> (rdata[7:0] == 8'hFF));
  assert_foreign_byte_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && foreign && sz == 2'd0) |=> (rdata[31:8] == 24'd0));
  assert_cmd_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_byte[7:3] == 5'd0);
endmodule

bind cfg_space cfg_space_chk #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .sz(sz),
  .rvalid(rvalid), .rdata(rdata), .cmd_byte(cfg_q[4])
);

// File: tb/cfg_space_test.sv
module cfg_space_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = 32'd0;
  logic [1:0]  sz = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic        rvalid;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] MYBUS = 8'h00;
  localparam logic [7:0] MYDF  = 8'h18;

  always #2.5 clk = ~clk;

  cfg_space uut (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
                 .sz(sz), .wdata(wdata), .rvalid(rvalid), .rdata(rdata));

  task automatic wr(input logic [7:0] bus, input logic [7:0] df, input logic [7:0] ofs,
                    input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {8'h80, bus, df, ofs}; sz = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] bus, input logic [7:0] df, input logic [7:0] ofs,
                    input logic [1:0] s, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = {8'h80, bus, df, ofs}; sz = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rl(input logic [7:0] ofs, input logic [1:0] s, input logic [31:0] e,
                    input string tag);
    rd(MYBUS, MYDF, ofs, s, e, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected rvalid, rdata=%08h expected no data", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %08h expected %08h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rvalid !== 1'b0 || rdata !== 32'd0) begin
      errors++;
      $display("FAIL R10: rvalid/rdata actual %b/%08h expected 0/00000000", rvalid, rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);

    rl(8'h00, 2'd2, 32'h0C31_1AB7, "R7 identity vendor/device");
    rl(8'h08, 2'd2, 32'h0200_0002, "R7 class/revision");
    rl(8'h10, 2'd2, 32'h0000_0000, "R10 mem base reset");
    rl(8'h14, 2'd2, 32'h0000_0001, "R10 io base reset type bit");
    rl(8'h3C, 2'd2, 32'h0000_0100, "R10 int line reset, R7 pin");
    rl(8'h02, 2'd1, 32'h0000_0C31, "R1 halfword little-endian");
    rl(8'h03, 2'd0, 32'h0000_000C, "R1 byte lane");

    wr(MYBUS, MYDF, 8'h04, 2'd2, 32'hFFFF_FFFF);
    rl(8'h04, 2'd2, 32'h0000_0007, "R3 command mask");
    wr(MYBUS, MYDF, 8'h04, 2'd0, 32'h0000_0002);
    rl(8'h04, 2'd0, 32'h0000_0002, "R2 command merge");

    wr(MYBUS, MYDF, 8'h0C, 2'd0, 32'hFFFF_FF5A);
    rl(8'h0C, 2'd2, 32'h0000_005A, "R4 cache line byte only");

    wr(MYBUS, MYDF, 8'h10, 2'd2, 32'hFFFF_FFFF);
    rl(8'h10, 2'd2, 32'hFFFF_F000, "R5 mem base sizing");
    wr(MYBUS, MYDF, 8'h14, 2'd2, 32'hFFFF_FFFF);
    rl(8'h14, 2'd2, 32'hFFFF_FFE1, "R5 io base sizing");
    wr(MYBUS, MYDF, 8'h14, 2'd2, 32'h0000_C000);
    rl(8'h14, 2'd2, 32'h0000_C001, "R2 R5 io base program");
    wr(MYBUS, MYDF, 8'h18, 2'd2, 32'hFFFF_FFFF);
    rl(8'h18, 2'd2, 32'h0000_0000, "R5 absent base");

    wr(MYBUS, MYDF, 8'h30, 2'd2, 32'hFFFF_FFFF);
    rl(8'h30, 2'd2, 32'hFFFF_0001, "R6 rom sizing with enable");

    wr(MYBUS, MYDF, 8'h3C, 2'd2, 32'hFFFF_FFFF);
    rl(8'h3C, 2'd2, 32'h0000_01FF, "R4 R7 int line writable, pin fixed");

    wr(MYBUS, MYDF, 8'h00, 2'd2, 32'h0000_0000);
    rl(8'h00, 2'd2, 32'h0C31_1AB7, "R7 identity write ignored");

    wr(MYBUS, MYDF, 8'h40, 2'd2, 32'h1122_3344);
    rl(8'h41, 2'd1, 32'h0000_2233, "R4 device area unaligned half");
    rl(8'h43, 2'd3, 32'h0000_0011, "R1 sz3 word clipped by R9? no, bytes 44-46 zero");

    wr(MYBUS, MYDF, 8'h80, 2'd1, 32'hDEAD_BEEF);
    rl(8'h80, 2'd2, 32'h0000_BEEF, "R1 halfword write width");

    wr(MYBUS, MYDF, 8'hFE, 2'd2, 32'hAABB_CCDD);
    rl(8'hFE, 2'd2, 32'h0000_CCDD, "R9 clip at end of space");
    rl(8'h00, 2'd1, 32'h0000_1AB7, "R9 no wrap to offset 0");

    wr(8'h01, MYDF, 8'h40, 2'd2, 32'hFFFF_FFFF);
    wr(MYBUS, 8'h20, 8'h40, 2'd2, 32'hFFFF_FFFF);
    rl(8'h40, 2'd2, 32'h1122_3344, "R8 foreign write ignored");
    rd(8'h01, MYDF, 8'h00, 2'd0, 32'h0000_00FF, "R8 foreign byte read");
    rd(MYBUS, 8'h20, 8'h00, 2'd1, 32'h0000_FFFF, "R8 foreign half read");
    rd(8'h05, 8'h07, 8'h00, 2'd2, 32'hFFFF_FFFF, "R8 foreign word read");

    wr(MYBUS, MYDF, 8'h50, 2'd2, 32'h0BAD_F00D);
    rl(8'h50, 2'd2, 32'h0BAD_F00D, "R11 write visible next read");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rl(8'h04, 2'd2, 32'h0000_0000, "R10 command cleared");
    rl(8'h0C, 2'd0, 32'h0000_0000, "R10 cache line cleared");
    rl(8'h14, 2'd2, 32'h0000_0001, "R10 io base restored");
    rl(8'h30, 2'd2, 32'h0000_0000, "R10 rom base cleared");
    rl(8'h40, 2'd2, 32'h0000_0000, "R10 device area cleared");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: pending reads actual %0d expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule